// File: doc/BRIEF.md
# Single-Bit Boolean Processor Unit

This unit carries out the single-bit instructions of a small microcontroller core. It keeps a one-bit carry that acts as the Boolean accumulator. It resolves an 8-bit bit address to a byte and a bit position in data memory, and it applies the operation to that bit. The space below 80h covers the sixteen bit-addressable RAM bytes that start at 20h. The space from 80h upward covers special registers whose byte address is a multiple of eight.

Bit reads use a combinational byte read from memory in the cycle the operation is accepted. Bit writes rewrite the whole containing byte one cycle later, and only the selected bit differs. The bit-addressable bytes therefore keep their normal byte access. The core's program-counter logic uses the branch-taken pulse to decide whether to jump. Fetch and program-counter update happen outside the unit.

The carry is owned here and is also bit 7 of the status register at D0h. When the unit reads that byte it inserts the live carry. When it writes that byte, the written bit 7 becomes the new carry.

Top module: `bool_bit_unit`

## Requirements
- R1: While reset is asserted and right after it, carry, branch_taken, mem_rd and mem_wr are all 0.
- R2: A bit address A below 80h drives mem_addr = 20h + A[6:3] during the read, and A[2:0] selects the bit.
- R3: A bit address A of 80h or above drives mem_addr = {A[7:3],000} during the read, and A[2:0] selects the bit (for example AFh is bit 7 of A8h).
- R4: Opcode 1 copies the bit into carry. Opcodes 2, 3 and 4 combine the bit into carry by OR, AND and XOR. The new carry appears in the cycle after acceptance, and memory is not written.
- R5: Opcodes 11, 12 and 13 set, clear and invert carry without a memory access (mem_rd stays 0). Carry never changes in a cycle that follows one without an accepted operation.
- R6: Opcodes 5, 6, 7 and 8 write carry into the bit, set it, clear it and invert it. Each is a read in the accepting cycle followed by a write of the same byte in the next cycle, and that write changes no bit except the selected one.
- R7: Opcode 9 (test-and-clear) pulses branch_taken and writes the bit to 0 when the bit is 1. When the bit is 0 it does not raise branch_taken and issues no write.
- R8: Opcode 10 (test) pulses branch_taken when the bit is 1 and never writes memory.
- R9: A read of the status byte D0h returns the live carry in bit 7. Any bit write into that byte sets carry to the written bit 7, so an explicit write to bit address D7h wins.
- R10: While a write cycle is in progress, op_valid is ignored: mem_rd stays 0 and carry is not affected.
- R11: branch_taken is high only in the cycle right after a taken test operation was accepted.
- R12: Opcode 0 and opcodes 14 and 15 have no effect: no memory access and no carry change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 4 | Operation code (see requirements) |
| bit_addr | input | 8 | Bit address |
| mem_addr | output | 8 | Byte address for read or write |
| mem_rd | output | 1 | Combinational byte read strobe |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_wr | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte write data |
| carry | output | 1 | Boolean accumulator |
| branch_taken | output | 1 | One-cycle branch decision pulse |

## Verification
On every cycle the assertions check four things. Each write follows a read of the same byte, and no two writes come back to back. Outside the status byte, a write changes at most one bit. A taken test-and-clear always drives its bit to 0. They also check that no read starts during a write and that carry holds when no operation was presented. Some results need a reference model of memory and carry, so only the bench's sweep can show them: whether the right bit is picked for each of the 256 addresses, the values of the combining operations, and the carry insertion into the status byte.

// File: rtl/bool_bit_unit.sv
module bool_bit_unit #(
  parameter logic [7:0] RAM_BASE    = 8'h20,
  parameter logic [7:0] STATUS_ADDR = 8'hD0,
  parameter int         CARRY_POS   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op_code,
  input  logic [7:0] bit_addr,
  output logic [7:0] mem_addr,
  output logic       mem_rd,
  input  logic [7:0] mem_rdata,
  output logic       mem_wr,
  output logic [7:0] mem_wdata,
  output logic       carry,
  output logic       branch_taken
);
  localparam logic [3:0] OP_MOVC = 4'd1, OP_ORC = 4'd2, OP_ANDC = 4'd3, OP_XORC = 4'd4,
                         OP_MOVB = 4'd5, OP_SETB = 4'd6, OP_CLRB = 4'd7, OP_CPLB = 4'd8,
                         OP_TCLR = 4'd9, OP_TEST = 4'd10,
                         OP_SETC = 4'd11, OP_CLRC = 4'd12, OP_CPLC = 4'd13;
  localparam logic [7:0] CMASK = 8'h1 << CARRY_POS;

  logic       busy_q, c_q, tk_q;
  logic [7:0] wa_q, wd_q;
  logic       nb, wr, nc, tk, needs_mem;

  wire        accept   = op_valid & ~busy_q;
  wire [7:0]  byte_sel = bit_addr[7] ? {bit_addr[7:3], 3'b000}
                                     : RAM_BASE + {4'h0, bit_addr[6:3]};
  wire [2:0]  idx      = bit_addr[2:0];
  wire        is_stat  = (byte_sel == STATUS_ADDR);
  wire [7:0]  rbyte    = is_stat ? ((mem_rdata & ~CMASK) | (c_q ? CMASK : 8'h00)) : mem_rdata;
  wire        bv       = rbyte[idx];
  wire [7:0]  bmask    = 8'h1 << idx;
  wire [7:0]  wbyte    = nb ? (rbyte | bmask) : (rbyte & ~bmask);

  always_comb begin
    nb = 1'b0;
    wr = 1'b0;
    nc = c_q;
    tk = 1'b0;
    needs_mem = 1'b1;
    case (op_code)
      OP_MOVC: nc = bv;
      OP_ORC:  nc = c_q | bv;
      OP_ANDC: nc = c_q & bv;
      OP_XORC: nc = c_q ^ bv;
      OP_MOVB: begin nb = c_q; wr = 1'b1; end
      OP_SETB: begin nb = 1'b1; wr = 1'b1; end
      OP_CLRB: begin nb = 1'b0; wr = 1'b1; end
      OP_CPLB: begin nb = ~bv;  wr = 1'b1; end
      OP_TCLR: begin nb = 1'b0; wr = bv; tk = bv; end
      OP_TEST: tk = bv;
      OP_SETC: begin nc = 1'b1; needs_mem = 1'b0; end
      OP_CLRC: begin nc = 1'b0; needs_mem = 1'b0; end
      OP_CPLC: begin nc = ~c_q; needs_mem = 1'b0; end
      default: needs_mem = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      c_q    <= 1'b0;
      tk_q   <= 1'b0;
      wa_q   <= 8'h00;
      wd_q   <= 8'h00;
    end else begin
      busy_q <= accept & wr;
      tk_q   <= accept & tk;
      if (accept & wr) begin
        wa_q <= byte_sel;
        wd_q <= wbyte;
      end
      if (accept)
        c_q <= (wr & is_stat) ? wbyte[CARRY_POS] : nc;
    end
  end

  assign mem_rd       = accept & needs_mem;
  assign mem_addr     = busy_q ? wa_q : byte_sel;
  assign mem_wr       = busy_q;
  assign mem_wdata    = wd_q;
  assign carry        = c_q;
  assign branch_taken = tk_q;
endmodule

// File: rtl/bool_bit_unit_chk.sv
module bool_bit_unit_chk #(
  parameter logic [7:0] STATUS_ADDR = 8'hD0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic [7:0] bit_addr,
  input logic [7:0] mem_addr,
  input logic       mem_rd,
  input logic [7:0] mem_rdata,
  input logic       mem_wr,
  input logic [7:0] mem_wdata,
  input logic       carry,
  input logic       branch_taken
);
  p_wr_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  p_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_addr != STATUS_ADDR) |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

  p_no_wr_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  p_no_rd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_rd);

  p_taken_after_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> $past(mem_rd));

  p_tclr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(op_code) == 4'd9) |-> (branch_taken && !mem_wdata[$past(bit_addr[2:0])]));

  p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> $stable(carry));
endmodule

bind bool_bit_unit bool_bit_unit_chk #(.STATUS_ADDR(STATUS_ADDR)) u_chk (.*);

// File: tb/bool_bit_unit_tb.sv
`timescale 1ns/1ps
module bool_bit_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] bit_addr = 8'd0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_rd, mem_wr, carry, branch_taken;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic       ref_c;
  int         total = 0, fails = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  bool_bit_unit u_dut (.*);

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] map_byte(input logic [7:0] a);
    return a[7] ? {a[7:3], 3'b000} : 8'h20 + {4'h0, a[6:3]};
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [7:0] a, input bit intrude);
    logic [7:0] ba, rb, wb;
    logic b, nb, wr, nc, tk, needs, stat;
    string tag, mtag;
    ba = map_byte(a);
    stat = (ba == 8'hD0);
    rb = ref_mem[ba];
    if (stat) rb[7] = ref_c;
    b = rb[a[2:0]];
    nb = 0; wr = 0; nc = ref_c; tk = 0;
    needs = (op >= 4'd1 && op <= 4'd10);
    case (op)
      4'd1: nc = b;
      4'd2: nc = ref_c | b;
      4'd3: nc = ref_c & b;
      4'd4: nc = ref_c ^ b;
      4'd5: begin nb = ref_c; wr = 1; end
      4'd6: begin nb = 1; wr = 1; end
      4'd7: begin nb = 0; wr = 1; end
      4'd8: begin nb = ~b; wr = 1; end
      4'd9: begin nb = 0; wr = b; tk = b; end
      4'd10: tk = b;
      4'd11: nc = 1;
      4'd12: nc = 0;
      4'd13: nc = ~ref_c;
      default: ;
    endcase
    wb = rb;
    wb[a[2:0]] = nb;
    if (wr && stat) nc = wb[7];
    if (op >= 4'd1 && op <= 4'd4) tag = "R4";
    else if (op >= 4'd5 && op <= 4'd8) tag = "R6";
    else if (op == 4'd9) tag = "R7";
    else if (op == 4'd10) tag = "R8";
    else if (op >= 4'd11 && op <= 4'd13) tag = "R5";
    else tag = "R12";
    if (stat && needs) tag = "R9";
    mtag = a[7] ? "R3" : "R2";

    @(negedge clk);
    op_valid = 1; op_code = op; bit_addr = a;
    #1;
    check(tag, "mem_rd", {7'h0, mem_rd}, {7'h0, needs});
    if (needs) check(mtag, "read addr", mem_addr, ba);
    @(negedge clk);
    if (intrude && wr) begin
      op_valid = 1; op_code = 4'd13; bit_addr = 8'h00;
    end else op_valid = 0;
    #1;
    if (intrude && wr) check("R10", "mem_rd while busy", {7'h0, mem_rd}, 8'h00);
    check(tag, "mem_wr", {7'h0, mem_wr}, {7'h0, wr});
    if (wr) begin
      check(tag, "write data", mem_wdata, wb);
      check(tag, "write addr", mem_addr, ba);
    end
    check((op == 4'd9 || op == 4'd10) ? "R11" : tag, "branch_taken", {7'h0, branch_taken}, {7'h0, tk});
    check(tag, "carry", {7'h0, carry}, {7'h0, nc});
    if (wr) ref_mem[ba] = wb;
    ref_c = nc;
    if (intrude && wr) begin
      @(negedge clk);
      op_valid = 0;
      #1;
      check("R10", "carry after ignored op", {7'h0, carry}, {7'h0, ref_c});
      check("R10", "no write after ignored op", {7'h0, mem_wr}, 8'h00);
    end
  endtask

  initial begin
    #1000000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    ref_c = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "carry in reset", {7'h0, carry}, 8'h00);
    check("R1", "branch in reset", {7'h0, branch_taken}, 8'h00);
    check("R1", "mem_wr in reset", {7'h0, mem_wr}, 8'h00);
    check("R1", "mem_rd in reset", {7'h0, mem_rd}, 8'h00);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1", "carry after reset", {7'h0, carry}, 8'h00);

    do_op(4'd11, 8'h00, 0);
    do_op(4'd9, 8'hD7, 0);
    do_op(4'd6, 8'hD7, 0);
    do_op(4'd1, 8'hD7, 0);
    do_op(4'd12, 8'h00, 0);
    do_op(4'd9, 8'h7F, 0);
    do_op(4'd9, 8'h7F, 0);
    do_op(4'd6, 8'h03, 1);
    do_op(4'd7, 8'hAF, 1);

    for (int a = 0; a < 256; a++)
      for (int op = 0; op < 16; op++)
        do_op(4'(op), 8'(a), (a % 5) == 0);

    for (int i = 0; i < 256; i++)
      check("R6", "final memory image", mem[i], ref_mem[i]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule